// File: doc/BRIEF.md
# Programmable Frame Wait Timer

A timeout counter for a contactless reader protocol engine, clocked at the carrier rate. A start pulse opens a waiting window. The engine then either reports that a frame arrived, which closes the window quietly, or the timer expires and raises a timeout pulse. When it expires, it also leaves the no-reception status code on its status output.

The window length is set by three fields: an exponent `pp_i`, a multiplier `mm_i` and an offset `dd_i`. A mode input picks one of three formulas:

- **Frame mode:** scales the offset term by a fixed shift.
- **Response mode:** uses a fixed base with no offset term.
- **Field-wait mode:** a plain prescaler times a count, for waits on the field.

The timer is built as three cascaded down-counter stages: base, multiplier and exponent. The settings are captured at start, so the inputs may change while a window runs. If a start carries reserved settings, the block flags it and does not start.

Top module: `fwt_timer`

## Requirements
- R1: With `mode_i`=2'b00 (frame), the window is T = 2^PP × (MM+1) × (DD+DD_OFFSET) × 2^FRAME_SHIFT cycles. The defaults are DD_OFFSET=128 and FRAME_SHIFT=5.
- R2: With `mode_i`=2'b01 (response), the window is T = 2^PP × (MM+1) × 2^FELICA_SHIFT cycles. The default FELICA_SHIFT is 12. `dd_i` is ignored in this mode, including values above DD_MAX.
- R3: With PP=MM=DD=0, frame and response modes give the same default window, DD_OFFSET×2^FRAME_SHIFT cycles. With the default parameters this is 4096 cycles.
- R4: With `mode_i`=2'b10 (field wait), the window is T = (PRESC+1) × (TMR+1) cycles. `pp_i`, `mm_i` and `dd_i` are ignored.
- R5: `timeout_o` is a one-cycle pulse. It rises exactly T clock edges after the edge that samples `start_i`. `busy_o` is high from the edge after that sample until the expiry edge.
- R6: On expiry, `status_o` becomes 8'h87.
- R7: A `frame_rx_i` pulse while busy stops the timer. It suppresses the timeout and sets `status_o` to 8'h80. While idle, `frame_rx_i` has no effect on `busy_o`, `timeout_o` or `status_o`.
- R8: A start with reserved settings raises `param_err_o` for one cycle and does not start the timer. Reserved settings are: PP>PP_MAX (default 14) in frame or response mode, DD>DD_MAX (127) in frame mode, or `mode_i`=2'b11.
- R9: A valid start while busy restarts a full window, timed from the new start.
- R10: After reset, `busy_o`, `timeout_o` and `param_err_o` are 0, and `status_o` is 8'h00.
- R11: A valid start clears `status_o` to 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Carrier-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a window |
| frame_rx_i | input | 1 | Valid frame received; stops the timer |
| mode_i | input | 2 | 00 frame, 01 response, 10 field wait, 11 reserved |
| pp_i | input | PP_W | Exponent |
| mm_i | input | MM_W | Multiplier |
| dd_i | input | DD_W | Offset |
| presc_i | input | PRESC_W | Field-wait prescaler |
| tmr_i | input | TMR_W | Field-wait count |
| busy_o | output | 1 | Window running |
| timeout_o | output | 1 | Expiry pulse |
| param_err_o | output | 1 | Start rejected for reserved settings |
| status_o | output | 8 | Last result code |

## Verification
The bench builds the timer with FRAME_SHIFT=1, DD_OFFSET=4, FELICA_SHIFT=3 and PP_MAX=3. With these values, every window in a full sweep of the exponent range, several multipliers and several offsets stays within a few hundred cycles.

This makes it possible to measure every legal exponent, the reserved exponent just above PP_MAX, and the largest legal offset of 127. It also covers every prescaler and count pair from 0 to 3 in field-wait mode.

The smaller constants also keep the zero-setting default window short. That lets the bench compare it across the two protocol modes directly.

// File: rtl/fwt_pkg.sv
package fwt_pkg;
  typedef enum logic [1:0] {
    MODE_FRAME  = 2'b00,
    MODE_FELICA = 2'b01,
    MODE_FIELD  = 2'b10,
    MODE_RSVD   = 2'b11
  } fwt_mode_e;

  localparam logic [7:0] ST_CLEAR   = 8'h00;
  localparam logic [7:0] ST_RX_OK   = 8'h80;
  localparam logic [7:0] ST_TIMEOUT = 8'h87;
endpackage

// File: rtl/fwt_cfg.sv
module fwt_cfg #(
  parameter int PP_W         = 4,
  parameter int MM_W         = 8,
  parameter int DD_W         = 8,
  parameter int PRESC_W      = 8,
  parameter int TMR_W        = 8,
  parameter int PP_MAX       = 14,
  parameter int DD_MAX       = 127,
  parameter int DD_OFFSET    = 128,
  parameter int FRAME_SHIFT  = 5,
  parameter int FELICA_SHIFT = 12,
  parameter int BASE_W       = 13,
  parameter int MUL_W        = 8,
  parameter int EXP_W        = 14
) (
  input  fwt_pkg::fwt_mode_e  mode_i,
  input  logic [PP_W-1:0]     pp_i,
  input  logic [MM_W-1:0]     mm_i,
  input  logic [DD_W-1:0]     dd_i,
  input  logic [PRESC_W-1:0]  presc_i,
  input  logic [TMR_W-1:0]    tmr_i,
  output logic                valid_o,
  output logic [BASE_W-1:0]   base_o,
  output logic [MUL_W-1:0]    mul_o,
  output logic [EXP_W-1:0]    exp_o
);
  import fwt_pkg::*;

  logic pp_ok, dd_ok;
  logic [31:0] exp_full, frame_base;

  // All outputs are "count minus one" reload values
  always_comb begin
    pp_ok      = 32'(pp_i) <= 32'(PP_MAX);
    dd_ok      = 32'(dd_i) <= 32'(DD_MAX);
    exp_full   = (32'd1 << pp_i) - 32'd1;
    frame_base = ((32'(dd_i) + 32'(DD_OFFSET)) << FRAME_SHIFT) - 32'd1;
    valid_o    = 1'b0;
    base_o     = '0;
    mul_o      = '0;
    exp_o      = '0;
    case (mode_i)
      MODE_FRAME: begin
        valid_o = pp_ok && dd_ok;
        base_o  = BASE_W'(frame_base);
        mul_o   = MUL_W'(mm_i);
        exp_o   = EXP_W'(exp_full);
      end
      MODE_FELICA: begin
        valid_o = pp_ok;
        base_o  = BASE_W'((32'd1 << FELICA_SHIFT) - 32'd1);
        mul_o   = MUL_W'(mm_i);
        exp_o   = EXP_W'(exp_full);
      end
      MODE_FIELD: begin
        valid_o = 1'b1;
        base_o  = BASE_W'(presc_i);
        mul_o   = MUL_W'(tmr_i);
        exp_o   = '0;
      end
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fwt_cnt_stage.sv
module fwt_cnt_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] init_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, rl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rl_q  <= '0;
    end else if (load_i) begin
      cnt_q <= init_i;
      rl_q  <= init_i;
    end else if (step_i) begin
      cnt_q <= (cnt_q == '0) ? rl_q : cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R5: a load seeds the stage with the requested count
  assert_stage_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(init_i)));
endmodule

// File: rtl/fwt_timer.sv
module fwt_timer #(
  parameter int PP_W         = 4,
  parameter int MM_W         = 8,
  parameter int DD_W         = 8,
  parameter int PRESC_W      = 8,
  parameter int TMR_W        = 8,
  parameter int PP_MAX       = 14,
  parameter int DD_MAX       = 127,
  parameter int DD_OFFSET    = 128,
  parameter int FRAME_SHIFT  = 5,
  parameter int FELICA_SHIFT = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               frame_rx_i,
  input  logic [1:0]         mode_i,
  input  logic [PP_W-1:0]    pp_i,
  input  logic [MM_W-1:0]    mm_i,
  input  logic [DD_W-1:0]    dd_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [TMR_W-1:0]   tmr_i,
  output logic               busy_o,
  output logic               timeout_o,
  output logic               param_err_o,
  output logic [7:0]         status_o
);
  import fwt_pkg::*;

  localparam int FRM_MAX  = (DD_MAX + DD_OFFSET) << FRAME_SHIFT;
  localparam int FEL_MAX  = 1 << FELICA_SHIFT;
  localparam int FLD_MAX  = 1 << PRESC_W;
  localparam int BASE_MAX = (FRM_MAX > FEL_MAX)
                            ? ((FRM_MAX > FLD_MAX) ? FRM_MAX : FLD_MAX)
                            : ((FEL_MAX > FLD_MAX) ? FEL_MAX : FLD_MAX);
  localparam int BASE_W   = $clog2(BASE_MAX + 1);
  localparam int MUL_W    = (MM_W > TMR_W) ? MM_W : TMR_W;
  localparam int EXP_W    = (PP_MAX > 0) ? PP_MAX : 1;

  logic              cfg_valid;
  logic [BASE_W-1:0] base_init;
  logic [MUL_W-1:0]  mul_init;
  logic [EXP_W-1:0]  exp_init;
  logic              base_zero, mul_zero, exp_zero;
  logic              busy_q, timeout_q, param_err_q;
  logic [7:0]        status_q;
  logic              start_ok, start_bad, expire, rx_stop;

  fwt_cfg #(
    .PP_W(PP_W), .MM_W(MM_W), .DD_W(DD_W), .PRESC_W(PRESC_W), .TMR_W(TMR_W),
    .PP_MAX(PP_MAX), .DD_MAX(DD_MAX), .DD_OFFSET(DD_OFFSET),
    .FRAME_SHIFT(FRAME_SHIFT), .FELICA_SHIFT(FELICA_SHIFT),
    .BASE_W(BASE_W), .MUL_W(MUL_W), .EXP_W(EXP_W)
  ) i_cfg (
    .mode_i  (fwt_mode_e'(mode_i)),
    .pp_i    (pp_i),
    .mm_i    (mm_i),
    .dd_i    (dd_i),
    .presc_i (presc_i),
    .tmr_i   (tmr_i),
    .valid_o (cfg_valid),
    .base_o  (base_init),
    .mul_o   (mul_init),
    .exp_o   (exp_init)
  );

  assign start_ok  = start_i && cfg_valid;
  assign start_bad = start_i && !cfg_valid;
  assign expire    = busy_q && base_zero && mul_zero && exp_zero;
  assign rx_stop   = busy_q && frame_rx_i;

  // Cascade: base period -> multiplier -> power-of-two exponent
  fwt_cnt_stage #(.W(BASE_W)) i_base (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(start_ok),
    .step_i(busy_q), .init_i(base_init), .zero_o(base_zero));

  fwt_cnt_stage #(.W(MUL_W)) i_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(start_ok),
    .step_i(busy_q && base_zero), .init_i(mul_init), .zero_o(mul_zero));

  fwt_cnt_stage #(.W(EXP_W)) i_exp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(start_ok),
    .step_i(busy_q && base_zero && mul_zero), .init_i(exp_init), .zero_o(exp_zero));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      timeout_q   <= 1'b0;
      param_err_q <= 1'b0;
      status_q    <= ST_CLEAR;
    end else begin
      timeout_q   <= 1'b0;
      param_err_q <= start_bad;
      if (start_ok) begin
        busy_q   <= 1'b1;
        status_q <= ST_CLEAR;
      end else if (rx_stop) begin
        busy_q   <= 1'b0;
        status_q <= ST_RX_OK;
      end else if (expire) begin
        busy_q    <= 1'b0;
        timeout_q <= 1'b1;
        status_q  <= ST_TIMEOUT;
      end
    end
  end

  assign busy_o      = busy_q;
  assign timeout_o   = timeout_q;
  assign param_err_o = param_err_q;
  assign status_o    = status_q;

  assert_timeout_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (status_o == ST_TIMEOUT));

  assert_timeout_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !busy_o);

  assert_rx_stops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && frame_rx_i && !start_i) |=> (!busy_o && !timeout_o && status_o == ST_RX_OK));

  assert_bad_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !cfg_valid && !busy_o) |=> (!busy_o && param_err_o));

  assert_idle_rx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> (!busy_o && $stable(status_o)));
endmodule

// File: tb/test_fwt_timer.sv
module test_fwt_timer;
  localparam int FSH = 1, DOFF = 4, FESH = 3, PPM = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, frx = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [3:0] pp = '0;
  logic [7:0] mm = '0, dd = '0, pr = '0, tm = '0;
  logic busy, tout, perr;
  logic [7:0] status;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fwt_timer #(
    .PP_MAX(PPM), .DD_OFFSET(DOFF), .FRAME_SHIFT(FSH), .FELICA_SHIFT(FESH)
  ) i_fwt_timer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .frame_rx_i(frx),
    .mode_i(mode), .pp_i(pp), .mm_i(mm), .dd_i(dd), .presc_i(pr), .tmr_i(tm),
    .busy_o(busy), .timeout_o(tout), .param_err_o(perr), .status_o(status));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic setup(input int md, input int p, input int m, input int d,
                       input int ps, input int t);
    mode = 2'(md); pp = 4'(p); mm = 8'(m); dd = 8'(d); pr = 8'(ps); tm = 8'(t);
  endtask

  // Starts a window and returns the negedge count until timeout_o is seen
  task automatic measure(input int limit, output int n, output bit gap);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0; gap = 1'b0;
    while (!tout && n <= limit) begin
      if (!busy) gap = 1'b1;
      @(negedge clk); n++;
    end
  endtask

  function automatic int t_frame(int p, int m, int d);
    return (1 << p) * (m + 1) * ((d + DOFF) << FSH);
  endfunction
  function automatic int t_resp(int p, int m);
    return (1 << p) * (m + 1) * (1 << FESH);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, e;
    bit gap;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !tout && !perr && status == 8'h00, "R10", int'(status), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 frame sweep
    for (int p = 0; p <= PPM; p++)
      for (int m = 0; m <= 2; m++)
        foreach (dd_set[k]) begin
          e = t_frame(p, m, dd_set[k]);
          setup(0, p, m, dd_set[k], 9, 9);
          measure(e + 4, n, gap);
          check(n == e && !gap, "R1", n, e);
        end
    e = t_frame(0, 0, 127);
    setup(0, 0, 0, 127, 0, 0);
    measure(e + 4, n, gap);
    check(n == e, "R1 dd_max", n, e);
    // R6 status after expiry
    check(status == 8'h87, "R6", int'(status), 'h87);

    // R11 valid start clears status
    setup(0, 1, 1, 1, 0, 0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(status == 8'h00 && busy, "R11", int'(status), 0);
    wait (tout == 1'b1); @(negedge clk);

    // R2 response sweep, dd above DD_MAX ignored
    for (int p = 0; p <= PPM; p++)
      for (int m = 0; m <= 3; m++) begin
        e = t_resp(p, m);
        setup(1, p, m, 200, 7, 7);
        measure(e + 4, n, gap);
        check(n == e && !gap, "R2", n, e);
      end

    // R3 zero-setting default equal across modes
    setup(0, 0, 0, 0, 0, 0);
    measure(100, n, gap);
    check(n == DOFF << FSH, "R3 frame", n, DOFF << FSH);
    setup(1, 0, 0, 0, 0, 0);
    measure(100, n, gap);
    check(n == DOFF << FSH, "R3 resp", n, DOFF << FSH);

    // R4 field-wait sweep, pp/mm/dd ignored
    for (int a = 0; a <= 3; a++)
      for (int b = 0; b <= 3; b++) begin
        e = (a + 1) * (b + 1);
        setup(2, 15, 200, 200, a, b);
        measure(e + 4, n, gap);
        check(n == e && !gap, "R4", n, e);
        // R5 single-cycle pulse
        @(negedge clk);
        check(!tout, "R5 pulse", int'(tout), 0);
      end

    // R8 reserved settings
    for (int c = 0; c < 4; c++) begin
      case (c)
        0: setup(0, PPM + 1, 0, 0, 0, 0);
        1: setup(1, PPM + 1, 0, 0, 0, 0);
        2: setup(0, 0, 0, 128, 0, 0);
        default: setup(3, 0, 0, 0, 0, 0);
      endcase
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(perr && !busy, "R8 flag", int'(perr), 1);
      gap = 1'b0;
      repeat (300) begin @(negedge clk); if (tout || busy) gap = 1'b1; end
      check(!gap && status == 8'h87, "R8 no start", int'(gap), 0);
    end

    // R7 frame received stops the window
    setup(0, 1, 1, 1, 0, 0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    frx = 1'b1;
    @(negedge clk); frx = 1'b0;
    check(!busy && status == 8'h80, "R7 stop", int'(status), 'h80);
    gap = 1'b0;
    repeat (60) begin @(negedge clk); if (tout) gap = 1'b1; end
    check(!gap, "R7 no timeout", int'(gap), 0);
    // R7 idle frame_rx ignored
    frx = 1'b1;
    @(negedge clk); frx = 1'b0;
    @(negedge clk);
    check(!busy && !tout && status == 8'h80, "R7 idle", int'(status), 'h80);

    // R9 restart while busy
    e = t_frame(1, 1, 1);
    setup(0, 1, 1, 1, 0, 0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (7) @(negedge clk);
    measure(e + 4, n, gap);
    check(n == e && !gap, "R9", n, e);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int dd_set[3] = '{0, 1, 5};
endmodule